// File: doc/BRIEF.md
# Special Bus Cycle Decoder

This block is system logic that listens to a processor front-side bus and picks out the special bus cycles. On every rising clock edge it registers the address strobe, the three status lines, the eight active-low byte enables and the upper address bits. A special cycle is one where the strobe is low and the status lines read code/special (`statDc` = 0), non-memory (`statMio` = 0) and write (`statWr` = 1), all on the same edge. For such a cycle the block decodes the byte enables together with address bits 4 and 3 into one of six kinds: halt, stop grant, flush acknowledge, writeback, flush or shutdown. It raises a one-clock pulse on that kind's bit of `eventPulse`.

Halt and stop grant share the same byte-enable pattern, so address bit 4 alone tells them apart. Every special cycle is ended with a single-clock low on `readyN`, and this includes special cycles whose encoding matches no known kind. An unknown encoding also sets a sticky error flag, so the processor never waits forever on the block. Memory and I/O cycles fall through untouched for other logic to answer. The delay from the sampling edge to the ready strobe is set by a parameter and can be 1, 2 or 3 clocks.

Top module: `spec_cycle_decoder`

## Requirements
- R1: A cycle is taken only when `addrStrobeN` = 0, `statDc` = 0, `statMio` = 0 and `statWr` = 1 are sampled on one rising edge. Any other status pattern gives no `readyN` low, no `eventPulse` bit and no change to `errorFlag`.
- R2: Byte enables 8'hFB with address bits [4:3] = 2'b10 and address bits [31:5] all zero decode as stop grant, `eventPulse` bit 1.
- R3: Byte enables 8'hFB with address bits [4:3] = 2'b00 and address bits [31:5] all zero decode as halt, `eventPulse` bit 0.
- R4: With address bits [4:3] = 2'b00 and [31:5] all zero, byte enables 8'hEF give flush acknowledge (bit 2), 8'hF7 give writeback (bit 3), 8'hFD give flush (bit 4) and 8'hFE give shutdown (bit 5).
- R5: For every accepted special cycle, of known or unknown kind, `readyN` is low for exactly one clock. The low starts READY_DELAY clock edges after the sampling edge.
- R6: The event pulse for an accepted cycle is high for exactly one clock, starting one edge after the sampling edge. At most one bit of `eventPulse` is high in any clock.
- R7: An accepted special cycle whose byte enables, bits [4:3] or bits [31:5] match none of the six encodings drives no event pulse. It sets `errorFlag` one edge after the sampling edge, and `errorFlag` stays set until reset.
- R8: Strobes sampled on the READY_DELAY edges that follow an accepted sampling edge are ignored. A strobe sampled on the next edge after those is accepted.
- R9: Out of reset `readyN` = 1, `eventPulse` = 0 and `errorFlag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addrStrobeN | input | 1 | Address strobe, active low |
| statDc | input | 1 | Data/code status, 0 for a special cycle |
| statMio | input | 1 | Memory/I-O status, 0 for a special cycle |
| statWr | input | 1 | Write/read status, 1 for a special cycle |
| byteEnN | input | 8 | Active-low byte enables |
| addrBus | input | ADDR_W-3 | Address bits ADDR_W-1 down to 3 |
| readyN | output | 1 | Cycle-end strobe to the processor, active low |
| eventPulse | output | 6 | One-clock pulse per decoded kind (bit 0 halt to bit 5 shutdown) |
| errorFlag | output | 1 | Sticky flag for unknown special encodings |

## Verification
The input registers capture the strobe on edge k. The event pulse and the error flag then change on edge k+1, and `readyN` falls on edge k+READY_DELAY and rises again one edge later. The bench drives inputs on the falling edge and reads outputs on later falling edges. For each edge from k to k+READY_DELAY+1 it knows which output should have moved and checks it there. The ignored window is probed the same way. A strobe is held through edges k+1 to k+READY_DELAY and must leave no pulse and no second ready. A strobe placed on the edge after that window must produce its pulse and its ready on the schedule above.

// File: rtl/spec_cycle_pkg.sv
package spec_cycle_pkg;

  localparam int NUM_KINDS = 6;
  localparam int BE_W      = 8;

  // event bit positions
  localparam int K_HALT     = 0;
  localparam int K_STOPGNT  = 1;
  localparam int K_FLUSHACK = 2;
  localparam int K_WRBACK   = 3;
  localparam int K_FLUSH    = 4;
  localparam int K_SHUTDOWN = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;  // capture decode result into pulse / error
    logic fire;   // end the cycle with ready
  } ctrl_strobe_t;

  function automatic logic [BE_W-1:0] kindBe(input int k);
    case (k)
      K_HALT:     return 8'hFB;
      K_STOPGNT:  return 8'hFB;
      K_FLUSHACK: return 8'hEF;
      K_WRBACK:   return 8'hF7;
      K_FLUSH:    return 8'hFD;
      default:    return 8'hFE;
    endcase
  endfunction

  function automatic logic [1:0] kindLow(input int k);
    return (k == K_STOPGNT) ? 2'b10 : 2'b00;
  endfunction

endpackage

// File: rtl/spec_cycle_dp.sv
module spec_cycle_dp
  import spec_cycle_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addrStrobeN,
  input  logic                 statDc,
  input  logic                 statMio,
  input  logic                 statWr,
  input  logic [BE_W-1:0]      byteEnN,
  input  logic [ADDR_W-1:3]    addrBus,
  input  ctrl_strobe_t         strobes,
  output logic                 hit,
  output logic [NUM_KINDS-1:0] eventPulse,
  output logic                 errorFlag
);

  logic            sStrobe;
  logic            sSpecial;
  logic [BE_W-1:0] sBe;
  logic [1:0]      sLow;
  logic            sUpperZero;

  // input register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sStrobe    <= 1'b0;
      sSpecial   <= 1'b0;
      sBe        <= '1;
      sLow       <= '0;
      sUpperZero <= 1'b1;
    end else begin
      sStrobe    <= ~addrStrobeN;
      sSpecial   <= ~statDc & ~statMio & statWr;
      sBe        <= byteEnN;
      sLow       <= addrBus[4:3];
      sUpperZero <= (addrBus[ADDR_W-1:5] == '0);
    end
  end

  assign hit = sStrobe & sSpecial;

  logic [NUM_KINDS-1:0] match;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign match[k] = (sBe == kindBe(k)) && (sLow == kindLow(k)) && sUpperZero;
  end

  logic known;
  assign known = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eventPulse <= '0;
      errorFlag  <= 1'b0;
    end else begin
      eventPulse <= strobes.latch ? match : '0;
      if (strobes.latch && !known) errorFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/spec_cycle_ctrl.sv
module spec_cycle_ctrl
  import spec_cycle_pkg::*;
#(
  parameter int READY_DELAY = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output ctrl_strobe_t strobes,
  output logic         readyN
);

  localparam int CNT_W = $clog2(READY_DELAY + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READY} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: begin
        if (hit) begin
          strobes.latch = 1'b1;
          strobes.fire  = (READY_DELAY == 1);
        end
      end
      ST_WAIT: strobes.fire = (cnt == CNT_W'(1));
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      readyN <= 1'b1;
    end else begin
      readyN <= ~strobes.fire;
      case (state)
        ST_IDLE: begin
          if (hit) begin
            cnt   <= CNT_W'(READY_DELAY - 1);
            state <= strobes.fire ? ST_READY : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (strobes.fire) state <= ST_READY;
          else              cnt   <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spec_cycle_decoder.sv
module spec_cycle_decoder
  import spec_cycle_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int READY_DELAY = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addrStrobeN,
  input  logic                 statDc,
  input  logic                 statMio,
  input  logic                 statWr,
  input  logic [7:0]           byteEnN,
  input  logic [ADDR_W-1:3]    addrBus,
  output logic                 readyN,
  output logic [5:0]           eventPulse,
  output logic                 errorFlag
);

  ctrl_strobe_t strobes;
  logic         hit;

  spec_cycle_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .addrStrobeN(addrStrobeN),
    .statDc     (statDc),
    .statMio    (statMio),
    .statWr     (statWr),
    .byteEnN    (byteEnN),
    .addrBus    (addrBus),
    .strobes    (strobes),
    .hit        (hit),
    .eventPulse (eventPulse),
    .errorFlag  (errorFlag)
  );

  spec_cycle_ctrl #(.READY_DELAY(READY_DELAY)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .strobes(strobes),
    .readyN (readyN)
  );

endmodule

// File: rtl/spec_cycle_checker.sv
module spec_cycle_checker #(
  parameter int READY_DELAY = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       readyN,
  input logic [5:0] eventPulse,
  input logic       errorFlag
);

  logic       armed;
  logic [1:0] waitLeft;

  // tracks when ready is due after a pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      waitLeft <= '0;
    end else if (eventPulse != '0 && READY_DELAY > 1) begin
      armed    <= 1'b1;
      waitLeft <= 2'(READY_DELAY - 2);
    end else if (armed) begin
      if (waitLeft == '0) armed <= 1'b0;
      else                waitLeft <= waitLeft - 2'd1;
    end
  end

  a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eventPulse));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (eventPulse != '0) |=> (eventPulse == '0));

  a_r5_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    !readyN |=> readyN);

  a_r5_ready_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((eventPulse != '0 && READY_DELAY == 1) || (armed && waitLeft == '0)) |-> !readyN);

  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errorFlag |=> errorFlag);

endmodule

bind spec_cycle_decoder spec_cycle_checker #(.READY_DELAY(READY_DELAY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .readyN    (readyN),
  .eventPulse(eventPulse),
  .errorFlag (errorFlag)
);

// File: tb/test_spec_cycle_decoder.sv
module test_spec_cycle_decoder;

  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addrStrobeN = 1'b1;
  logic        statDc = 1'b1;
  logic        statMio = 1'b1;
  logic        statWr = 1'b0;
  logic [7:0]  byteEnN = 8'hFF;
  logic [31:3] addrBus = '0;
  logic        readyN;
  logic [5:0]  eventPulse;
  logic        errorFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  spec_cycle_decoder #(.ADDR_W(32), .READY_DELAY(DLY)) i_spec_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .addrStrobeN(addrStrobeN), .statDc(statDc),
    .statMio(statMio), .statWr(statWr), .byteEnN(byteEnN), .addrBus(addrBus),
    .readyN(readyN), .eventPulse(eventPulse), .errorFlag(errorFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveSpecial(input logic [7:0] be, input logic [31:0] addr);
    addrStrobeN = 1'b0; statDc = 1'b0; statMio = 1'b0; statWr = 1'b1;
    byteEnN = be; addrBus = addr[31:3];
  endtask

  task automatic driveIdle();
    addrStrobeN = 1'b1; statDc = 1'b1; statMio = 1'b1; statWr = 1'b0;
    byteEnN = 8'hFF; addrBus = '0;
  endtask

  // one special cycle, checked edge by edge
  task automatic runSpecial(input logic [7:0] be, input logic [31:0] addr,
                            input logic [5:0] expPulse, input logic expErr, input string req);
    @(negedge clk); driveSpecial(be, addr);
    @(negedge clk); driveIdle();          // after sampling edge k
    chk(eventPulse == '0, {req, " pulse early"}, 32'(eventPulse), 0);
    chk(readyN == 1'b1, "R5 ready early", 32'(readyN), 1);
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk);                     // after edge k+i
      if (i == 1) begin
        chk(eventPulse == expPulse, req, 32'(eventPulse), 32'(expPulse));
        chk(errorFlag == expErr, {req, " R7 error"}, 32'(errorFlag), 32'(expErr));
      end else begin
        chk(eventPulse == '0, "R6 pulse width", 32'(eventPulse), 0);
      end
      chk(readyN == (i == DLY ? 1'b0 : 1'b1), "R5 ready timing", 32'(readyN), (i == DLY) ? 0 : 1);
    end
    @(negedge clk);
    chk(readyN == 1'b1, "R5 ready width", 32'(readyN), 1);
  endtask

  task automatic testReset();
    chk(readyN == 1'b1, "R9 readyN", 32'(readyN), 1);
    chk(eventPulse == '0, "R9 eventPulse", 32'(eventPulse), 0);
    chk(errorFlag == 1'b0, "R9 errorFlag", 32'(errorFlag), 0);
  endtask

  task automatic testKinds();
    runSpecial(8'hFB, 32'h0,  6'b000001, 1'b0, "R3 halt");
    runSpecial(8'hFB, 32'h10, 6'b000010, 1'b0, "R2 stop grant");
    runSpecial(8'hEF, 32'h0,  6'b000100, 1'b0, "R4 flush ack");
    runSpecial(8'hF7, 32'h0,  6'b001000, 1'b0, "R4 writeback");
    runSpecial(8'hFD, 32'h0,  6'b010000, 1'b0, "R4 flush");
    runSpecial(8'hFE, 32'h0,  6'b100000, 1'b0, "R4 shutdown");
  endtask

  task automatic testOrdinary();
    @(negedge clk); driveSpecial(8'hFB, 32'h0); statMio = 1'b1;   // I/O-less memory cycle
    @(negedge clk); driveSpecial(8'hFB, 32'h0); statWr = 1'b0;    // read
    @(negedge clk); driveSpecial(8'hFB, 32'h0); statDc = 1'b1;    // data
    @(negedge clk); driveSpecial(8'hFB, 32'h0); addrStrobeN = 1'b1; // no strobe
    @(negedge clk); driveIdle();
    for (int i = 0; i < DLY + 3; i++) begin
      chk(readyN == 1'b1, "R1 ordinary ready", 32'(readyN), 1);
      chk(eventPulse == '0, "R1 ordinary pulse", 32'(eventPulse), 0);
      chk(errorFlag == 1'b0, "R1 ordinary error", 32'(errorFlag), 0);
      @(negedge clk);
    end
  endtask

  task automatic testUnknown();
    runSpecial(8'h7F, 32'h0,  6'b000000, 1'b1, "R7 unknown byte enables");
    runSpecial(8'hFB, 32'h08, 6'b000000, 1'b1, "R7 bad low bits");
    runSpecial(8'hFB, 32'h30, 6'b000000, 1'b1, "R7 upper bits stop grant");
    runSpecial(8'hFE, 32'h80000000, 6'b000000, 1'b1, "R7 upper bits shutdown");
    runSpecial(8'hF7, 32'h0,  6'b001000, 1'b1, "R7 sticky after valid");
  endtask

  // strobe held through the ignored window, then a new one just after
  task automatic testWindow();
    @(negedge clk); driveSpecial(8'hFB, 32'h0);            // sampled at edge k
    @(negedge clk); driveSpecial(8'hFE, 32'h0);            // edges k+1..k+DLY
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk);                                       // after edge k+i
      if (i == 1)
        chk(eventPulse == 6'b000001, "R8 first pulse", 32'(eventPulse), 1);
      else
        chk(eventPulse == '0, "R8 ignored pulse", 32'(eventPulse), 0);
      chk(readyN == (i == DLY ? 1'b0 : 1'b1), "R8 first ready", 32'(readyN), (i == DLY) ? 0 : 1);
    end
    driveSpecial(8'hFD, 32'h0);                             // sampled at edge k+DLY+1
    @(negedge clk); driveIdle();
    chk(eventPulse == '0, "R8 ignored strobe pulse", 32'(eventPulse), 0);
    chk(readyN == 1'b1, "R8 ignored strobe ready", 32'(readyN), 1);
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk);
      if (i == 1)
        chk(eventPulse == 6'b010000, "R8 accepted flush", 32'(eventPulse), 6'b010000);
      else
        chk(eventPulse == '0, "R8 accepted pulse width", 32'(eventPulse), 0);
      chk(readyN == (i == DLY ? 1'b0 : 1'b1), "R8 second ready", 32'(readyN), (i == DLY) ? 0 : 1);
    end
    @(negedge clk);
    chk(readyN == 1'b1, "R8 second ready width", 32'(readyN), 1);
    chk(eventPulse == '0, "R8 no extra pulse", 32'(eventPulse), 0);
    chk(errorFlag == 1'b0, "R8 no error", 32'(errorFlag), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testOrdinary();
    testKinds();
    testWindow();
    testUnknown();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule